// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an asynchronous DRAM out of power-up and then keeps its contents alive with CAS-before-RAS refresh. Once reset is released it counts out the power-up pause, then takes the memory pins without asking and runs a fixed number of back-to-back warm-up refresh cycles. Only after those have finished does it raise `ready`, which tells the access controller that normal reads and writes may begin.

From then on an interval timer adds one owed refresh every `REF_PERIOD_CYC / ROWS` clocks, which spreads all rows evenly over the retention period. While at least one refresh is owed and no cycle is running, the block raises `bus_req`. The access controller answers with `bus_grant` at a point between its own accesses. While `own_bus` is high, the controller must route the block's RAS, CAS, write-enable, output-enable and address levels to the memory and leave the data bus undriven. A completed cycle removes one owed refresh. When the backlog reaches a set level, `urgent` tells the controller to stop delaying the grant. The row address comes from the memory's internal counter, so `addr` is held at zero.

Top module: `dram_refresh_seq`

## Requirements
- R1: During reset and in the first sample after reset release, `ras_n`, `cas_n`, `we_n` and `oe_n` are 1, `addr` is 0, and `ready`, `bus_req`, `own_bus` and `urgent` are 0.
- R2: No refresh starts before `PWRUP_CYC` clock edges after reset release. The first warm-up cycle starts at that edge, with CAS first low in the sample after edge `PWRUP_CYC`+1, and it needs no grant.
- R3: Exactly `WARMUP_CNT` warm-up cycles run, each separated from the next by one idle cycle. `ready` rises in the sample after the last one completes. While `ready` is 0, `bus_req` is 0 and `bus_grant` has no effect.
- R4: Each refresh cycle is CAS low with RAS high for `CSR_CYC` cycles, then RAS and CAS both low for `RAS_CYC` cycles, then both high for `RP_CYC` cycles (active-low pins, 0 = asserted).
- R5: `we_n` and `oe_n` stay 1, `addr` stays 0, and `dq_oe` stays 0 at all times, including during refresh.
- R6: `own_bus` is 1 exactly during the `CSR_CYC+RAS_CYC+RP_CYC` cycles of a refresh and 0 otherwise.
- R7: After `ready` rises, the owed count rises by one every `REF_PERIOD_CYC/ROWS` cycles, with the first increment that many cycles after `ready` rises.
- R8: `bus_req` equals `ready` AND (owed > 0) AND no cycle in progress. A cycle starts at the edge where `bus_req` and `bus_grant` are both 1. A grant while `bus_req` is 0 has no effect.
- R9: The owed count drops by one when a post-warm-up cycle completes. If an interval ends in the same cycle, the count is unchanged. The count saturates at 2^`OWED_W`-1.
- R10: `urgent` is 1 exactly when the owed count is at least `URGENT_LVL` (always 0 if `URGENT_LVL` is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_grant | input | 1 | Access controller hands the memory pins over |
| bus_req | output | 1 | Refresh owed and block idle |
| ready | output | 1 | Warm-up complete; normal accesses allowed |
| urgent | output | 1 | Owed backlog at or above threshold |
| own_bus | output | 1 | Block is driving the memory control pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high (refresh, not test entry) |
| oe_n | output | 1 | Output enable, held inactive |
| addr | output | ADDR_W | Address lines, held at zero |
| dq_oe | output | 1 | Data bus drive enable, always off |

## Verification
The assertions assume that the controller raises `bus_grant` only as a reply to `bus_req`. They also assume that `bus_grant` is stable around the clock edge, so that a sampled grant and a sampled request start exactly one cycle. The stimulus drives the grant at the falling edge. It mixes a random 50 % grant with long stretches of no grant, which saturate the owed count. It also includes stretches of constant grant and stretches where the grant is held high while no request is pending, so the cases where the grant must be ignored are covered. The warm-up phase is run with random grants as well, to show that the block ignores them before `ready`.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_CSETUP = 2'd1,
      PH_RASLO  = 2'd2,
      PH_PRECH  = 2'd3
   } rfsh_phase_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/rfsh_timers.sv
module rfsh_timers #(
   parameter int PWRUP_CYC    = 40000,
   parameter int INTERVAL_CYC = 3125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ready,
   output logic pwr_done,
   output logic tick
);
   localparam int PW_W = $clog2(PWRUP_CYC + 1);
   localparam int IV_W = $clog2(INTERVAL_CYC + 1);

   logic [PW_W-1:0] pcnt;
   logic [IV_W-1:0] icnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt     <= '0;
         pwr_done <= 1'b0;
      end else if (!pwr_done) begin
         if (pcnt == PW_W'(PWRUP_CYC - 1)) pwr_done <= 1'b1;
         pcnt <= pcnt + 1'b1;
      end
   end

   assign tick = ready && (icnt == IV_W'(INTERVAL_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      icnt <= '0;
      else if (!ready) icnt <= '0;
      else if (tick)   icnt <= '0;
      else             icnt <= icnt + 1'b1;
   end

   // R7
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/rfsh_owed_ctr.sv
module rfsh_owed_ctr #(
   parameter int OWED_W     = 3,
   parameter int URGENT_LVL = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic owed_nz,
   output logic urgent
);
   localparam logic [OWED_W-1:0] OWED_MAX = {OWED_W{1'b1}};

   logic [OWED_W-1:0] owed;
   logic              dec_ok;
   logic              inc_ok;

   assign dec_ok  = dec && (owed != '0);
   assign inc_ok  = inc && (owed != OWED_MAX);
   assign owed_nz = (owed != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 owed <= '0;
      else if (inc_ok && !dec_ok) owed <= owed + 1'b1;
      else if (dec_ok && !inc)    owed <= owed - 1'b1;
   end

   generate
      if (URGENT_LVL == 0) begin : g_no_urgent
         assign urgent = 1'b0;
      end else begin : g_urgent
         assign urgent = (owed >= OWED_W'(URGENT_LVL));
      end
   endgenerate

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owed == OWED_MAX && inc && !dec) |=> owed == OWED_MAX);
   // R9
   inc_dec_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && dec && owed != '0) |=> $stable(owed));
   // R7
   count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec && owed != OWED_MAX) |=> owed == OWED_W'($past(owed) + 1'b1));
endmodule

// File: rtl/rfsh_cbr_engine.sv
module rfsh_cbr_engine
   import rfsh_pkg::*;
#(
   parameter int CSR_CYC = 2,
   parameter int RAS_CYC = 12,
   parameter int RP_CYC  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done,
   output logic ras_n,
   output logic cas_n
);
   localparam int CW = $clog2(max3(CSR_CYC, RAS_CYC, RP_CYC) + 1);

   rfsh_phase_e     phase;
   logic [CW-1:0]   cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (start) begin
               phase <= PH_CSETUP;
               cnt   <= CW'(CSR_CYC - 1);
            end
            PH_CSETUP: if (cnt == '0) begin
               phase <= PH_RASLO;
               cnt   <= CW'(RAS_CYC - 1);
            end else cnt <= cnt - 1'b1;
            PH_RASLO: if (cnt == '0) begin
               phase <= PH_PRECH;
               cnt   <= CW'(RP_CYC - 1);
            end else cnt <= cnt - 1'b1;
            PH_PRECH: if (cnt == '0) begin
               phase <= PH_IDLE;
            end else cnt <= cnt - 1'b1;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy  = (phase != PH_IDLE);
   assign done  = (phase == PH_PRECH) && (cnt == '0);
   assign ras_n = (phase != PH_RASLO);
   assign cas_n = !((phase == PH_CSETUP) || (phase == PH_RASLO));

   logic [CW-1:0] ras_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ras_run <= '0;
      else if (!ras_n) ras_run <= ras_run + 1'b1;
      else             ras_run <= '0;
   end

   // R4
   cas_before_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
   // R4
   cas_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n |-> !cas_n);
   // R4
   ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> ras_run == CW'(RAS_CYC));
   // R4
   precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> cas_n);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
   parameter int ADDR_W         = 11,
   parameter int PWRUP_CYC      = 40000,
   parameter int WARMUP_CNT     = 8,
   parameter int REF_PERIOD_CYC = 6400000,
   parameter int ROWS           = 2048,
   parameter int CSR_CYC        = 2,
   parameter int RAS_CYC        = 12,
   parameter int RP_CYC         = 8,
   parameter int OWED_W         = 3,
   parameter int URGENT_LVL     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_grant,
   output logic              bus_req,
   output logic              ready,
   output logic              urgent,
   output logic              own_bus,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic              oe_n,
   output logic [ADDR_W-1:0] addr,
   output logic              dq_oe
);
   localparam int INTERVAL_CYC = REF_PERIOD_CYC / ROWS;
   localparam int CYCLE_LEN    = CSR_CYC + RAS_CYC + RP_CYC;
   localparam int WARM_W       = $clog2(WARMUP_CNT + 1);

   generate
      if (CSR_CYC < 1 || RAS_CYC < 1 || RP_CYC < 1) begin : g_bad_phase
         $error("refresh phase lengths must be at least one cycle");
      end
      if (WARMUP_CNT < 1 || PWRUP_CYC < 1) begin : g_bad_warm
         $error("power-up pause and warm-up count must be positive");
      end
      if (INTERVAL_CYC <= CYCLE_LEN) begin : g_bad_interval
         $error("refresh interval must exceed one refresh cycle");
      end
      if (URGENT_LVL > (2 ** OWED_W) - 1) begin : g_bad_urgent
         $error("urgent threshold does not fit the owed counter");
      end
   endgenerate

   logic              pwr_done;
   logic              tick;
   logic              busy;
   logic              done;
   logic              start;
   logic              owed_nz;
   logic [WARM_W-1:0] warm_cnt;

   assign ready   = (warm_cnt == WARM_W'(WARMUP_CNT));
   assign bus_req = ready && owed_nz && !busy;
   assign start   = !busy && ((pwr_done && !ready) || (bus_req && bus_grant));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              warm_cnt <= '0;
      else if (done && !ready) warm_cnt <= warm_cnt + 1'b1;
   end

   rfsh_timers #(
      .PWRUP_CYC    (PWRUP_CYC),
      .INTERVAL_CYC (INTERVAL_CYC)
   ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ready    (ready),
      .pwr_done (pwr_done),
      .tick     (tick)
   );

   rfsh_owed_ctr #(
      .OWED_W     (OWED_W),
      .URGENT_LVL (URGENT_LVL)
   ) u_owed (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (tick),
      .dec     (done && ready),
      .owed_nz (owed_nz),
      .urgent  (urgent)
   );

   rfsh_cbr_engine #(
      .CSR_CYC (CSR_CYC),
      .RAS_CYC (RAS_CYC),
      .RP_CYC  (RP_CYC)
   ) u_cbr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .done  (done),
      .ras_n (ras_n),
      .cas_n (cas_n)
   );

   assign own_bus = busy;
   assign we_n    = 1'b1;
   assign oe_n    = 1'b1;
   assign addr    = '0;
   assign dq_oe   = 1'b0;

   // R3
   no_req_before_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !bus_req);
   // R8
   start_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_grant) |=> (own_bus && !cas_n && ras_n));
   // R8
   grant_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !bus_req && !own_bus) |=> !own_bus);
   // R10
   urgent_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
      urgent |-> (bus_req || own_bus));
   // R5
   we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      own_bus |-> (we_n && oe_n));
endmodule

// File: tb/sim_dram_refresh_seq.sv
module sim_dram_refresh_seq;
   localparam int AW   = 11;
   localparam int P    = 50;
   localparam int W    = 8;
   localparam int REFP = 320;
   localparam int ROWS = 8;
   localparam int INTV = REFP / ROWS;
   localparam int CSR  = 2;
   localparam int RASC = 12;
   localparam int RPC  = 8;
   localparam int TOT  = CSR + RASC + RPC;
   localparam int OW   = 3;
   localparam int LVL  = 3;
   localparam int OMAX = (1 << OW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_grant = 1'b0;
   logic          bus_req, ready, urgent, own_bus, ras_n, cas_n, we_n, oe_n, dq_oe;
   logic [AW-1:0] addr;

   always #2.5 clk = ~clk;

   dram_refresh_seq #(
      .ADDR_W(AW), .PWRUP_CYC(P), .WARMUP_CNT(W), .REF_PERIOD_CYC(REFP),
      .ROWS(ROWS), .CSR_CYC(CSR), .RAS_CYC(RASC), .RP_CYC(RPC),
      .OWED_W(OW), .URGENT_LVL(LVL)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .bus_req(bus_req),
      .ready(ready), .urgent(urgent), .own_bus(own_bus), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_oe(dq_oe)
   );

   int checks = 0;
   int bad    = 0;

   // reference state, derived from the requirements
   int m_pcnt = 0, m_warm = 0, m_k = 0, m_owed = 0, m_icnt = 0;
   bit m_pwr = 0, m_busy = 0;
   int sample = 0;
   int ready_at = -1, first_cas = -1, warm_starts = 0;
   bit urgent_seen = 0;
   int mode = 0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s at sample %0d: act=%0d exp=%0d", tag, what, sample, act, exp);
      end
   endtask

   function automatic bit m_ready();
      return m_warm == W;
   endfunction
   function automatic bit exp_ras_n();
      return !(m_busy && m_k > CSR && m_k <= CSR + RASC);
   endfunction
   function automatic bit exp_cas_n();
      return !(m_busy && m_k <= CSR + RASC);
   endfunction
   function automatic bit exp_req();
      return m_ready() && m_owed != 0 && !m_busy;
   endfunction

   task automatic step_model(input bit g);
      bit rdy, dn, st, inc, dec;
      rdy = m_ready();
      dn  = m_busy && m_k == TOT;
      st  = !m_busy && ((m_pwr && !rdy) || (rdy && m_owed != 0 && g));
      inc = rdy && m_icnt == INTV - 1;
      dec = dn && rdy && m_owed != 0;
      if (st && !rdy) warm_starts++;
      if (!m_pwr) begin
         if (m_pcnt == P - 1) m_pwr = 1;
         m_pcnt++;
      end
      if (inc && !dec && m_owed != OMAX) m_owed++;
      else if (dec && !inc)              m_owed--;
      if (!rdy || inc) m_icnt = 0; else m_icnt++;
      if (dn && !rdy) m_warm++;
      if (st) begin m_busy = 1; m_k = 1; end
      else if (dn) m_busy = 0;
      else if (m_busy) m_k++;
   endtask

   task automatic do_cycle();
      string t;
      t = (sample == 0) ? "R1" : "";
      chk({t, " R2 R4"}, "ras_n", ras_n, exp_ras_n());
      chk({t, " R2 R4"}, "cas_n", cas_n, exp_cas_n());
      chk({t, " R5"}, "we_n", we_n, 1);
      chk({t, " R5"}, "oe_n", oe_n, 1);
      chk({t, " R5"}, "addr", addr, 0);
      chk(" R5", "dq_oe", dq_oe, 0);
      chk({t, " R6"}, "own_bus", own_bus, m_busy);
      chk({t, " R3"}, "ready", ready, m_ready());
      chk({t, " R7 R8 R9"}, "bus_req", bus_req, exp_req());
      chk({t, " R10 R9"}, "urgent", urgent, (m_owed >= LVL));
      if (ready && ready_at < 0) ready_at = sample;
      if (!cas_n && first_cas < 0) first_cas = sample;
      if (urgent) urgent_seen = 1;
      unique case (mode)
         0: bus_grant = $urandom_range(0, 1) == 1;
         1: bus_grant = 1'b0;
         2: bus_grant = 1'b1;
         default: bus_grant = !bus_req || ($urandom_range(0, 3) == 0);
      endcase
      step_model(bus_grant);
      sample++;
   endtask

   task automatic run(input int n, input int md);
      mode = md;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         do_cycle();
      end
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      int seed;
      seed = 1234;
      void'($urandom(seed));
      repeat (4) @(negedge clk);
      // R1: reset state while rst_n is still low
      chk("R1", "ras_n in reset", ras_n, 1);
      chk("R1", "ready in reset", ready, 0);
      chk("R1", "bus_req in reset", bus_req, 0);
      rst_n = 1'b1;
      do_cycle();
      run(700, 0);    // random grants, including during warm-up (R3)
      // R2: CAS first low in sample P+1
      chk("R2", "first cas sample", first_cas, P + 1);
      // R3: ready rises after W warm-up cycles with one idle gap each
      chk("R3", "ready sample", ready_at, P + W * (TOT + 1));
      chk("R3", "warm-up count", warm_starts, W);
      run(450, 1);    // withhold grant: saturation (R9) and urgent (R10)
      chk("R10", "urgent seen", urgent_seen, 1);
      chk("R9", "urgent while saturated", urgent, 1);
      run(300, 2);    // constant grant drains the backlog
      chk("R9", "backlog drained", urgent, 0);
      run(600, 3);    // grant held while no request (R8)
      run(600, 0);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule